// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page mappings in a small fully associative table. Every slot stores a valid flag, a virtual page tag, an 8-bit address-space number, a global flag that makes the slot match in any address space, a physical page number, per-privilege-mode read and write enable masks, and two bits that force a fault on read or on write. A lookup is purely combinational. It compares the requested page and address-space number against every slot in the same cycle and returns hit, slot index and the stored fields.

New mappings are written through an insert port into the slot named by a rotating victim pointer. Three flush commands remove mappings:
- a full flush empties the table;
- a process flush drops every non-global slot;
- a page flush drops the slots that translate one page in one address space.

All writes take effect at the rising clock edge. A lookup in the same cycle sees the table as it was before that edge.

Top module: `asid_tlb`

## Requirements
- R1: A slot hits only when it is valid, its tag equals the lookup page number, and either its global flag is 1 or its stored address-space number equals the lookup one. A hit sets `lk_hit`=1 and puts the slot number on `lk_idx`.
- R2: An insert writes the slot at the victim pointer and replaces any mapping held there. The pointer then advances by one and wraps from ENTRIES-1 to 0, so the ENTRIES+1-th insert after a full flush lands in slot 0.
- R3: A full flush, or a synchronous reset, clears every valid flag and returns the victim pointer to slot 0. It overrides any insert or other flush in the same cycle.
- R4: A process flush invalidates every slot whose global flag is 0, leaves global slots intact, and does not move the victim pointer.
- R5: A page flush invalidates, in one cycle, every valid slot whose tag equals `fl_vpn` and which is either global or carries `fl_asn`. Other slots are kept.
- R6: An inserted slot takes its tag from bits [VA_W-1:PG_OFS] of `ins_va` and has its valid flag forced to 1. A later hit on it returns the inserted ppn, masks and fault bits.
- R7: When several slots match, the lowest-numbered one is reported.
- R8: Inserts and flushes apply at the clock edge, and a lookup in the same cycle returns the old state. When an insert and a process or page flush coincide, the inserted slot is written valid and the flush acts on the other slots.
- R9: On a miss, `lk_idx`, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_f_rd`, `lk_f_wr` and `lk_global` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as a full flush |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | log2(ENTRIES) | Index of the reported slot |
| lk_ppn | output | PPN_W | Physical page of the reported slot |
| lk_rd_en | output | NMODES | Per-mode read enable mask |
| lk_wr_en | output | NMODES | Per-mode write enable mask |
| lk_f_rd | output | 1 | Fault-on-read bit |
| lk_f_wr | output | 1 | Fault-on-write bit |
| lk_global | output | 1 | Global flag of the reported slot |
| ins_en | input | 1 | Insert a mapping at the victim slot |
| ins_va | input | VA_W | Virtual address; its page field becomes the tag |
| ins_asn | input | ASN_W | Address-space number of the new mapping |
| ins_global | input | 1 | Global flag of the new mapping |
| ins_ppn | input | PPN_W | Physical page of the new mapping |
| ins_rd_en | input | NMODES | Read enable mask of the new mapping |
| ins_wr_en | input | NMODES | Write enable mask of the new mapping |
| ins_f_rd | input | 1 | Fault-on-read bit of the new mapping |
| ins_f_wr | input | 1 | Fault-on-write bit of the new mapping |
| fl_all | input | 1 | Full flush |
| fl_proc | input | 1 | Flush all non-global slots |
| fl_page | input | 1 | Flush one page in one address space |
| fl_vpn | input | VPN_W | Page number for the page flush |
| fl_asn | input | ASN_W | Address-space number for the page flush |

## Verification
Some properties are checked on every cycle:
- the reported index is always a matching slot, and no lower slot matches;
- the victim pointer wraps correctly;
- a full flush empties the table;
- a process flush keeps exactly the global slots;
- a page flush leaves no slot matching the flushed page;
- a fresh insert is valid with the inserted tag.

Other behaviour depends on the stored contents over many operations, and only the bench scenarios show it:
- the exact rotation order, seen through `lk_idx`;
- round-trip field values;
- zeroed fields on a miss;
- same-cycle lookups returning the old state;
- how an insert combines with a flush in the same cycle.

The bench tracks these against its own model of the table.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PG_OFS = 12;
    localparam int VA_W   = VPN_W + PG_OFS;
    localparam int PPN_W  = 20;
    localparam int ASN_W  = 8;
    localparam int NMODES = 4;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  tag;
        logic [ASN_W-1:0]  asn;
        logic              glob;
        logic [PPN_W-1:0]  ppn;
        logic [NMODES-1:0] rd_en;
        logic [NMODES-1:0] wr_en;
        logic              f_rd;
        logic              f_wr;
    } tlb_ent_t;

    function automatic logic ent_hits(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                      logic [ASN_W-1:0] asn);
        return e.valid && (e.tag == vpn) && (e.glob || (e.asn == asn));
    endfunction
endpackage

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
    import asid_tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  tlb_ent_t         ents [N],
    input  logic [VPN_W-1:0] vpn,
    input  logic [ASN_W-1:0] asn,
    output logic [N-1:0]     hv
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hv[g] = ent_hits(ents[g], vpn, asn);
    end
endmodule

// File: rtl/tlb_lowest_pick.sv
module tlb_lowest_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hv,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    logic [N-1:0] below;
    always_comb begin
        for (int i = 0; i < N; i++) below[i] = (i < int'(idx));
    end

    // R1 / R7: reported slot matches and no lower slot does
    p_pick_lowest_r7: assert property (@(posedge clk) disable iff (rst)
        found |-> (hv[idx] && ((hv & below) == '0)));
    p_miss_none_r1: assert property (@(posedge clk) disable iff (rst)
        !found |-> (hv == '0));
endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)  ptr <= '0;
        else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && ptr == LAST) |=> (ptr == '0));
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(ptr));
    p_ptr_clr_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IW-1:0]     lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [NMODES-1:0] lk_rd_en,
    output logic [NMODES-1:0] lk_wr_en,
    output logic              lk_f_rd,
    output logic              lk_f_wr,
    output logic              lk_global,
    input  logic              ins_en,
    input  logic [VA_W-1:0]   ins_va,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_global,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [NMODES-1:0] ins_rd_en,
    input  logic [NMODES-1:0] ins_wr_en,
    input  logic              ins_f_rd,
    input  logic              ins_f_wr,
    input  logic              fl_all,
    input  logic              fl_proc,
    input  logic              fl_page,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASN_W-1:0]  fl_asn
);
    tlb_ent_t             ents [ENTRIES];
    logic [ENTRIES-1:0]   lk_hv;
    logic [ENTRIES-1:0]   pg_hv;
    logic [ENTRIES-1:0]   valid_vec;
    logic [ENTRIES-1:0]   glob_vec;
    logic [IW-1:0]        vptr;
    logic                 pick_found;
    logic [IW-1:0]        pick_idx;
    tlb_ent_t             new_ent;
    tlb_ent_t             sel;

    tlb_match_vec #(.N(ENTRIES)) i_lk_cmp (
        .ents(ents), .vpn(lk_vpn), .asn(lk_asn), .hv(lk_hv));

    tlb_match_vec #(.N(ENTRIES)) i_pg_cmp (
        .ents(ents), .vpn(fl_vpn), .asn(fl_asn), .hv(pg_hv));

    tlb_lowest_pick #(.N(ENTRIES)) i_pick (
        .clk(clk), .rst(rst), .hv(lk_hv), .found(pick_found), .idx(pick_idx));

    tlb_victim_ctr #(.N(ENTRIES)) i_vptr (
        .clk(clk), .rst(rst), .clr(fl_all), .adv(ins_en), .ptr(vptr));

    always_comb begin
        new_ent.valid = 1'b1;
        new_ent.tag   = ins_va[VA_W-1:PG_OFS];
        new_ent.asn   = ins_asn;
        new_ent.glob  = ins_global;
        new_ent.ppn   = ins_ppn;
        new_ent.rd_en = ins_rd_en;
        new_ent.wr_en = ins_wr_en;
        new_ent.f_rd  = ins_f_rd;
        new_ent.f_wr  = ins_f_wr;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst || fl_all) begin
                ents[i] <= '0;
            end else if (ins_en && (vptr == IW'(i))) begin
                ents[i] <= new_ent;
            end else if ((fl_proc && !ents[i].glob) || (fl_page && pg_hv[i])) begin
                ents[i].valid <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign valid_vec[g] = ents[g].valid;
        assign glob_vec[g]  = ents[g].glob;
    end

    always_comb begin
        sel = pick_found ? ents[pick_idx] : '0;
    end

    assign lk_hit    = pick_found;
    assign lk_idx    = pick_idx;
    assign lk_ppn    = sel.ppn;
    assign lk_rd_en  = sel.rd_en;
    assign lk_wr_en  = sel.wr_en;
    assign lk_f_rd   = sel.f_rd;
    assign lk_f_wr   = sel.f_wr;
    assign lk_global = sel.glob;

    p_flush_all_r3: assert property (@(posedge clk) disable iff (rst)
        fl_all |=> (valid_vec == '0));
    p_proc_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (fl_proc && !fl_all && !ins_en) |=>
        ((valid_vec & ~glob_vec) == '0) &&
        ((valid_vec & glob_vec) == $past(valid_vec & glob_vec)));
    p_page_gone_r5: assert property (@(posedge clk) disable iff (rst)
        (fl_page && !fl_all && !ins_en) |=> ((valid_vec & $past(pg_hv)) == '0));
    p_ins_written_r6: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !fl_all) |=>
        (valid_vec[$past(vptr)] &&
         ents[$past(vptr)].tag == $past(ins_va[VA_W-1:PG_OFS])));
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ppn == '0 && lk_idx == '0 && lk_rd_en == '0 &&
                     lk_wr_en == '0 && !lk_f_rd && !lk_f_wr && !lk_global));
endmodule

// File: tb/test_asid_tlb.sv
`timescale 1ns/100ps
module test_asid_tlb;
    import asid_tlb_pkg::*;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic [VPN_W-1:0] lk_vpn = 0;  logic [ASN_W-1:0] lk_asn = 0;
    logic lk_hit; logic [IW-1:0] lk_idx; logic [PPN_W-1:0] lk_ppn;
    logic [NMODES-1:0] lk_rd_en, lk_wr_en; logic lk_f_rd, lk_f_wr, lk_global;
    logic ins_en = 0; logic [VA_W-1:0] ins_va = 0; logic [ASN_W-1:0] ins_asn = 0;
    logic ins_global = 0; logic [PPN_W-1:0] ins_ppn = 0;
    logic [NMODES-1:0] ins_rd_en = 0, ins_wr_en = 0; logic ins_f_rd = 0, ins_f_wr = 0;
    logic fl_all = 0, fl_proc = 0, fl_page = 0;
    logic [VPN_W-1:0] fl_vpn = 0; logic [ASN_W-1:0] fl_asn = 0;

    asid_tlb #(.ENTRIES(N)) i_asid_tlb (.*);

    // bench model of the table
    logic m_v [N]; logic [VPN_W-1:0] m_tag [N]; logic [ASN_W-1:0] m_asn [N];
    logic m_g [N]; logic [PPN_W-1:0] m_ppn [N]; logic [NMODES-1:0] m_rd [N], m_wr [N];
    logic m_fr [N], m_fw [N]; int m_ptr;
    int total = 0, bad = 0;

    function automatic int exp_idx(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_tag[i] == v && (m_g[i] || m_asn[i] == a)) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_tag[i] = 0; m_asn[i] = 0; m_g[i] = 0; m_ppn[i] = 0;
            m_rd[i] = 0; m_wr[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic model_edge();
        logic pgm [N];
        if (rst || fl_all) begin model_clear(); return; end
        for (int i = 0; i < N; i++)
            pgm[i] = m_v[i] && m_tag[i] == fl_vpn && (m_g[i] || m_asn[i] == fl_asn);
        for (int i = 0; i < N; i++) begin
            if (ins_en && m_ptr == i) begin
                m_v[i] = 1; m_tag[i] = ins_va[VA_W-1:PG_OFS]; m_asn[i] = ins_asn;
                m_g[i] = ins_global; m_ppn[i] = ins_ppn; m_rd[i] = ins_rd_en;
                m_wr[i] = ins_wr_en; m_fr[i] = ins_f_rd; m_fw[i] = ins_f_wr;
            end else if ((fl_proc && !m_g[i]) || (fl_page && pgm[i])) m_v[i] = 0;
        end
        if (ins_en) m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    endtask

    task automatic check(string req);
        int e = exp_idx(lk_vpn, lk_asn);
        logic [63:0] got, expv;
        got  = {lk_hit, 3'(lk_idx), lk_ppn, lk_rd_en, lk_wr_en, lk_f_rd, lk_f_wr, lk_global};
        if (e < 0) expv = '0;
        else expv = {1'b1, 3'(e), m_ppn[e], m_rd[e], m_wr[e], m_fr[e], m_fw[e], m_g[e]};
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s vpn=%0h asn=%0h actual=%h expected=%h", req, lk_vpn, lk_asn, got, expv);
        end
    endtask

    // check lookup before the edge, then apply the edge to the model
    task automatic step(string req);
        #1 check(req);
        @(posedge clk); model_edge();
        @(negedge clk);
        ins_en = 0; fl_all = 0; fl_proc = 0; fl_page = 0;
    endtask

    task automatic look(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, string req);
        lk_vpn = v; lk_asn = a; step(req);
    endtask

    task automatic put(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic g, logic [PPN_W-1:0] p);
        ins_en = 1; ins_va = {v, 12'hABC}; ins_asn = a; ins_global = g; ins_ppn = p;
        ins_rd_en = p[3:0]; ins_wr_en = p[7:4]; ins_f_rd = p[8]; ins_f_wr = p[9];
    endtask

    task automatic expect_idx(int want, string req);
        total++;
        if (!(lk_hit && int'(lk_idx) == want)) begin
            bad++;
            $display("FAIL %s actual hit=%0b idx=%0d expected idx=%0d", req, lk_hit, lk_idx, want);
        end
    endtask

    initial begin
        #200000;
        bad++; $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        @(negedge clk); @(negedge clk);
        rst = 0;
        look(20'h5, 8'h0, "R3 reset empty");
        // fill the table: R2 order
        for (int i = 0; i < N; i++) begin put(20'h100 + i, 8'h1, 0, 20'h300 + i); lk_vpn = 20'h100 + i; step("R8 same-cycle old"); end
        for (int i = 0; i < N; i++) begin lk_vpn = 20'h100 + i; lk_asn = 1; #1 expect_idx(i, "R2 rotation"); step("R6 fields"); end
        put(20'h200, 8'h1, 0, 20'h3FF); step("R2 wrap insert");
        lk_vpn = 20'h200; #1 expect_idx(0, "R2 wrap slot 0"); step("R2 wrap");
        look(20'h100, 8'h1, "R2 overwritten");
        look(20'h101, 8'h2, "R1 asn mismatch");
        // global + duplicates
        put(20'h777, 8'h9, 1, 20'h3A5); step("R6 global insert");   // slot 1
        put(20'h777, 8'h2, 0, 20'h155); step("R7 dup insert");      // slot 2
        look(20'h777, 8'h4, "R1 global any asn");
        lk_vpn = 20'h777; lk_asn = 2; #1 expect_idx(1, "R7 lowest"); step("R7");
        // page flush removes both
        fl_page = 1; fl_vpn = 20'h777; fl_asn = 8'h2; step("R5 page flush");
        look(20'h777, 8'h2, "R5 gone");
        look(20'h777, 8'h9, "R5 global gone");
        look(20'h103, 8'h1, "R5 others kept");
        // process flush
        put(20'h888, 8'h3, 1, 20'h2C3); step("R4 setup");
        fl_proc = 1; step("R4 proc flush");
        look(20'h888, 8'h0, "R4 global kept");
        look(20'h104, 8'h1, "R4 nonglobal gone");
        put(20'h999, 8'h3, 0, 20'h011); step("R4 ptr");
        lk_vpn = 20'h999; lk_asn = 3; #1 expect_idx(4, "R4 pointer unchanged"); step("R4");
        // insert with flush same cycle
        put(20'hAAA, 8'h3, 0, 20'h022); fl_proc = 1; step("R8 insert+flush");
        look(20'hAAA, 8'h3, "R8 insert survives");
        // flush all, then insert lands in slot 0
        fl_all = 1; put(20'hBBB, 8'h1, 0, 20'h1); step("R3 flush all");
        look(20'h888, 8'h0, "R3 empty");
        put(20'hCCC, 8'h1, 0, 20'h2); step("R3 insert");
        lk_vpn = 20'hCCC; lk_asn = 1; #1 expect_idx(0, "R3 pointer zero"); step("R3");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 99);
            lk_vpn = 20'($urandom_range(0, 15)); lk_asn = 8'($urandom_range(0, 3));
            if (r < 40) put(20'($urandom_range(0, 15)), 8'($urandom_range(0, 3)),
                            1'($urandom_range(0, 1)), 20'($urandom));
            if (r >= 90 && r < 94) fl_proc = 1;
            if (r >= 94 && r < 99) begin
                fl_page = 1; fl_vpn = 20'($urandom_range(0, 15)); fl_asn = 8'($urandom_range(0, 3));
            end
            if (r == 99) fl_all = 1;
            step("R1 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule